// File: doc/BRIEF.md
# Configuration Port Address Translator

This block turns accesses to a 16-bit internal I/O port space into physical memory addresses, following the classic two-port scheme for reaching device configuration space. A 32-bit configuration-address register sits behind port 0xCF8. Software loads it with a target location and an enable bit. It then reads or writes the four-port data window at 0xCFC..0xCFF to reach that location.

Each request carries a port number, a byte size and a read/write flag. One cycle later the block returns one of four results. A register access carries the current register value and no address. A window access goes to the configuration region when the stored enable bit is set, and to the plain I/O region otherwise. Any other port goes to the plain I/O region. An illegal size returns an error. Every access that produces an address is tagged uncacheable and strictly ordered. The two region prefixes are parameters.

Top module: `pci_cfg_port_xlate`

## Requirements
- R1: After reset `rsp_valid` is low and the configuration-address register holds zero, so a window access first maps to the I/O region.
- R2: A request with `req_size` = 4 to port 0xCF8 is a register access. On a write it loads `req_wdata` into the register. The response has `rsp_regacc` = 1, `rsp_paddr` = 0 and `rsp_rdata` equal to the register value held before that request.
- R3: A window access (port with bits 1:0 cleared equal to 0xCFC) while register bit 31 is 1 yields `CFG_BASE | {reg[30:2], port[1:0]}`, with bits 30:2 at their own positions.
- R4: A window access while register bit 31 is 0 yields `IO_BASE | port`.
- R5: Any legal-size access to a port that is neither the register nor the window yields `IO_BASE | port`.
- R6: `rsp_uncached` and `rsp_strict` are both 1 for every window and I/O result, and both 0 for register and error results.
- R7: An access to 0xCF8 with size 1 or 2 is an ordinary I/O access and leaves the register unchanged.
- R8: A `req_size` other than 1, 2 or 4 gives `rsp_err` = 1, `rsp_paddr` = 0 and no flags, and never changes the register.
- R9: Each result appears with `rsp_valid` exactly one cycle after the request cycle. `rsp_valid` is 0 in a cycle that follows a cycle with no request.
- R10: A register write takes effect for a window access issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 16 | I/O port number |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data for the register port |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 64 | Translated physical address |
| rsp_uncached | output | 1 | Access must bypass caches |
| rsp_strict | output | 1 | Access must stay strictly ordered |
| rsp_regacc | output | 1 | Result was an internal register access |
| rsp_rdata | output | 32 | Register value for register accesses, else 0 |
| rsp_err | output | 1 | Illegal access size |

## Verification
All results come from a single output register. Every field of a response is therefore due at the first rising edge after the request cycle. The bench drives each request on a falling edge, waits for the next rising edge, and compares all fields a short delay later against a bench model of the register. It updates that model only after the comparison. Back-to-back requests check that a register write changes the window mapping of the next cycle. An idle cycle checks that `rsp_valid` drops one edge after the requests stop.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [2:0] {
    KIND_IO  = 3'd0,
    KIND_CFG = 3'd1,
    KIND_REG = 3'd2,
    KIND_ERR = 3'd3
  } pcx_kind_e;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/pcx_cfg_reg.sv
module pcx_cfg_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/pcx_decode.sv
module pcx_decode
  import pcx_pkg::*;
#(
  parameter int          PORT_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          PADDR_W  = 64,
  parameter logic [15:0] REG_PORT = 16'h0CF8,
  parameter logic [15:0] WIN_PORT = 16'h0CFC,
  parameter logic [PADDR_W-1:0] CFG_BASE = '0,
  parameter logic [PADDR_W-1:0] IO_BASE  = '0
) (
  input  logic               req_valid,
  input  logic [PORT_W-1:0]  port,
  input  logic [2:0]         size,
  input  logic               write,
  input  logic [DATA_W-1:0]  cfg,
  output pcx_kind_e          kind,
  output logic [PADDR_W-1:0] paddr,
  output logic               uncached,
  output logic               strict,
  output logic [DATA_W-1:0]  rdata,
  output logic               reg_wr
);
  localparam int EN_BIT = DATA_W - 1;
  localparam int HI_BIT = DATA_W - 2;

  logic legal, hit_reg, hit_win;

  always_comb begin
    legal   = size_ok(size);
    hit_reg = (port == PORT_W'(REG_PORT)) && (size == 3'd4);
    hit_win = (port[PORT_W-1:2] == WIN_PORT[PORT_W-1:2]);

    kind     = KIND_IO;
    paddr    = '0;
    uncached = 1'b0;
    strict   = 1'b0;
    rdata    = '0;
    reg_wr   = 1'b0;

    if (!legal) begin
      kind = KIND_ERR;
    end else if (hit_reg) begin
      kind   = KIND_REG;
      rdata  = cfg;
      reg_wr = req_valid && write;
    end else if (hit_win && cfg[EN_BIT]) begin
      kind     = KIND_CFG;
      paddr    = CFG_BASE
               | PADDR_W'({cfg[HI_BIT:2], 2'b00})
               | PADDR_W'(port[1:0]);
      uncached = 1'b1;
      strict   = 1'b1;
    end else begin
      kind     = KIND_IO;
      paddr    = IO_BASE | PADDR_W'(port);
      uncached = 1'b1;
      strict   = 1'b1;
    end
  end
endmodule

// File: rtl/pcx_out_reg.sv
module pcx_out_reg
  import pcx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  pcx_kind_e          in_kind,
  input  logic [PADDR_W-1:0] in_paddr,
  input  logic               in_uncached,
  input  logic               in_strict,
  input  logic [DATA_W-1:0]  in_rdata,
  output logic               out_valid,
  output logic [PADDR_W-1:0] out_paddr,
  output logic               out_uncached,
  output logic               out_strict,
  output logic               out_regacc,
  output logic [DATA_W-1:0]  out_rdata,
  output logic               out_err
);
  logic               valid_d;
  logic [PADDR_W-1:0] paddr_d;
  logic               unc_d, str_d, reg_d, err_d;
  logic [DATA_W-1:0]  rdata_d;

  always_comb begin
    valid_d = in_valid;
    paddr_d = out_paddr;
    unc_d   = out_uncached;
    str_d   = out_strict;
    reg_d   = out_regacc;
    rdata_d = out_rdata;
    err_d   = out_err;
    if (in_valid) begin
      paddr_d = in_paddr;
      unc_d   = in_uncached;
      str_d   = in_strict;
      reg_d   = (in_kind == KIND_REG);
      rdata_d = in_rdata;
      err_d   = (in_kind == KIND_ERR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_paddr    <= '0;
      out_uncached <= 1'b0;
      out_strict   <= 1'b0;
      out_regacc   <= 1'b0;
      out_rdata    <= '0;
      out_err      <= 1'b0;
    end else begin
      out_valid    <= valid_d;
      out_paddr    <= paddr_d;
      out_uncached <= unc_d;
      out_strict   <= str_d;
      out_regacc   <= reg_d;
      out_rdata    <= rdata_d;
      out_err      <= err_d;
    end
  end
endmodule

// File: rtl/pci_cfg_port_xlate.sv
module pci_cfg_port_xlate
  import pcx_pkg::*;
#(
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 64,
  parameter logic [PADDR_W-1:0] CFG_BASE = 64'h2000_0000_0000_0000,
  parameter logic [PADDR_W-1:0] IO_BASE  = 64'h1000_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PORT_W-1:0]  req_port,
  input  logic [2:0]         req_size,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_uncached,
  output logic               rsp_strict,
  output logic               rsp_regacc,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err
);
  logic [DATA_W-1:0]  cfg_q;
  pcx_kind_e          dec_kind;
  logic [PADDR_W-1:0] dec_paddr;
  logic               dec_unc, dec_str, dec_wr;
  logic [DATA_W-1:0]  dec_rdata;

  pcx_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(dec_wr), .wr_data(req_wdata), .q(cfg_q)
  );

  pcx_decode #(
    .PORT_W(PORT_W), .DATA_W(DATA_W), .PADDR_W(PADDR_W),
    .CFG_BASE(CFG_BASE), .IO_BASE(IO_BASE)
  ) u_dec (
    .req_valid(req_valid), .port(req_port), .size(req_size),
    .write(req_write), .cfg(cfg_q), .kind(dec_kind), .paddr(dec_paddr),
    .uncached(dec_unc), .strict(dec_str), .rdata(dec_rdata), .reg_wr(dec_wr)
  );

  pcx_out_reg #(.DATA_W(DATA_W), .PADDR_W(PADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_kind(dec_kind),
    .in_paddr(dec_paddr), .in_uncached(dec_unc), .in_strict(dec_str),
    .in_rdata(dec_rdata), .out_valid(rsp_valid), .out_paddr(rsp_paddr),
    .out_uncached(rsp_uncached), .out_strict(rsp_strict),
    .out_regacc(rsp_regacc), .out_rdata(rsp_rdata), .out_err(rsp_err)
  );
endmodule

// File: rtl/pcx_checker.sv
module pcx_checker #(
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 32,
  parameter int PADDR_W = 64,
  parameter logic [PADDR_W-1:0] IO_BASE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [PORT_W-1:0]  req_port,
  input logic [2:0]         req_size,
  input logic               rsp_valid,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic               rsp_uncached,
  input logic               rsp_strict,
  input logic               rsp_regacc,
  input logic               rsp_err
);
  logic plain_io;
  assign plain_io = req_valid
                 && ((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4))
                 && (req_port[PORT_W-1:2] != 14'h033F)
                 && !((req_port == 16'h0CF8) && (req_size == 3'd4));

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_FLAGS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_uncached == rsp_strict)); // R6
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0 && !rsp_uncached)); // R8
  AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_regacc) |-> (rsp_paddr == '0 && !rsp_strict && !rsp_err)); // R2
  AST_IO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    plain_io |=> (rsp_paddr == (IO_BASE | PADDR_W'($past(req_port))))); // R5
  AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_regacc, rsp_err, rsp_uncached})); // R6
endmodule

bind pci_cfg_port_xlate pcx_checker #(
  .PORT_W(PORT_W), .DATA_W(DATA_W), .PADDR_W(PADDR_W), .IO_BASE(IO_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_uncached(rsp_uncached), .rsp_strict(rsp_strict),
  .rsp_regacc(rsp_regacc), .rsp_err(rsp_err)
);

// File: tb/pci_cfg_port_xlate_test.sv
`timescale 1ns/1ps
module pci_cfg_port_xlate_test;
  localparam logic [63:0] CFGB = 64'h2000_0000_0000_0000;
  localparam logic [63:0] IOB  = 64'h1000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_port;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_uncached, rsp_strict, rsp_regacc, rsp_err;
  logic [63:0] rsp_paddr;
  logic [31:0] rsp_rdata;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] model_cfg;

  always #5 clk = ~clk;

  pci_cfg_port_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_strict(rsp_strict), .rsp_regacc(rsp_regacc), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  function automatic logic legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  // expected {paddr, unc, strict, regacc, rdata, err}
  function automatic logic [100:0] expect_rsp(input logic [15:0] p, input logic [2:0] s,
                                              input logic [31:0] cfg);
    logic [63:0] a; logic u, st, r, e; logic [31:0] d;
    a = '0; u = 0; st = 0; r = 0; e = 0; d = '0;
    if (!legal(s)) e = 1;
    else if (p == 16'h0CF8 && s == 3'd4) begin r = 1; d = cfg; end
    else if ((p & 16'hFFFC) == 16'h0CFC && cfg[31]) begin
      a = CFGB | {32'h0, 1'b0, cfg[30:2], p[1:0]}; u = 1; st = 1;
    end else begin
      a = IOB | {48'h0, p}; u = 1; st = 1;
    end
    return {a, u, st, r, d, e};
  endfunction

  task automatic check(input string req, input logic [100:0] exp);
    logic [100:0] act;
    act = {rsp_paddr, rsp_uncached, rsp_strict, rsp_regacc, rsp_rdata, rsp_err};
    vectors++;
    if (!rsp_valid || act !== exp) begin
      fails++;
      $display("FAIL %s valid=%0b actual=%h expected=%h", req, rsp_valid, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [15:0] p, input logic [2:0] s,
                        input logic w, input logic [31:0] wd);
    logic [100:0] exp;
    @(negedge clk);
    req_valid = 1; req_port = p; req_size = s; req_write = w; req_wdata = wd;
    exp = expect_rsp(p, s, model_cfg);
    @(posedge clk); #1;
    check(req, exp);
    if (w && legal(s) && p == 16'h0CF8 && s == 3'd4) model_cfg = wd;
  endtask

  task automatic idle;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] p; logic [2:0] s; logic [31:0] wd;
    void'($urandom(32'h5EED_0C8F));
    rst_n = 0; req_valid = 0; req_port = 0; req_size = 0; req_write = 0; req_wdata = 0;
    model_cfg = '0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R1 rsp_valid actual=%0b expected=0", rsp_valid);
    end
    @(negedge clk) rst_n = 1;

    access("R1 window after reset", 16'h0CFD, 3'd1, 0, 0);
    access("R2 read cfg at reset", 16'h0CF8, 3'd4, 0, 0);
    access("R2 write cfg", 16'h0CF8, 3'd4, 1, 32'h8001_2344);
    access("R10 R3 window next cycle", 16'h0CFE, 3'd2, 0, 0);
    access("R2 read back", 16'h0CF8, 3'd4, 0, 0);
    access("R7 byte to cf8", 16'h0CF8, 3'd1, 1, 32'h0000_0000);
    access("R7 halfword to cf8", 16'h0CF8, 3'd2, 1, 32'h0000_0000);
    access("R7 register unchanged", 16'h0CF8, 3'd4, 0, 0);
    access("R8 size 3 write cf8", 16'h0CF8, 3'd3, 1, 32'h0);
    access("R8 size 0", 16'h0080, 3'd0, 0, 0);
    access("R8 register unchanged", 16'h0CF8, 3'd4, 0, 0);
    access("R3 window top byte", 16'h0CFF, 3'd1, 1, 0);
    access("R5 neighbour port", 16'h0CFB, 3'd1, 0, 0);
    access("R5 port 0xFFFF", 16'hFFFF, 3'd4, 1, 0);
    access("R2 clear enable", 16'h0CF8, 3'd4, 1, 32'h7FFF_FFFF);
    access("R10 R4 window disabled", 16'h0CFC, 3'd4, 0, 0);
    idle();
    @(posedge clk); #1;
    vectors++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R9 idle rsp_valid actual=%0b expected=0", rsp_valid);
    end

    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 3))
        0: p = 16'h0CF8;
        1: p = 16'h0CFC | 16'($urandom_range(0, 3));
        default: p = 16'($urandom);
      endcase
      s  = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd4;
      wd = $urandom;
      access("R3/R4/R5/R6 random", p, s, 1'($urandom), wd);
      if ($urandom_range(0, 9) == 0) idle();
    end
    idle();
    @(posedge clk); #1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule